// File: doc/BRIEF.md
# Self-Triggered Hit Detector with Timestamping

This block is the digital stage of one detector channel. It receives a free-running stream of 10-bit ADC samples, with no external trigger. It subtracts a tracked baseline from each sample. It finds pulses on its own and measures the height of each pulse above the baseline. It also marks each pulse with an arrival time: a coarse sample index plus a fraction of a sample in eighths. For every pulse, the block pushes one record into a small buffer. A downstream concentrator drains that buffer and later groups hits into events by their time.

Two detection styles are available at run time. In edge mode, the time is the interpolated point where the signal crosses the threshold. In peak mode, the time is the sample that holds the pulse maximum. After a pulse ends, a programmable number of samples is ignored. When the buffer is full, new records are lost and counted.

Top module: `autotrig_hit_unit`

## Requirements
- R1: The first valid sample after reset only seeds the baseline: the accumulator is set to that sample shifted left by the effective shift. That sample can never produce a hit.
- R2: The baseline is the accumulator shifted right by the effective shift, where the effective shift is `bl_shift` clamped to SHIFT_LIMIT. On a sample that is examined while idle and does not start a hit, the accumulator becomes acc + sample - baseline. It is frozen on every other sample and on every cycle without `smp_valid`.
- R3: The excess of a sample is sample minus baseline, or 0 if the sample lies below the baseline. The amplitude of a hit is the largest excess seen from its opening sample up to the sample before its closing one.
- R4: A hit opens, while idle, on a sample whose excess is at least `thr` and whose previous valid sample had an excess below `thr`. A level that is merely held above threshold opens nothing.
- R5: A hit closes on the first later sample whose excess is below `thr`. Its record is offered on `rec_valid` from the cycle after that sample is taken.
- R6: Edge mode (`det_mode`=0) uses the opening sample n, its excess e and the previous excess p. If e equals `thr`, the time is coarse n, fine 0. Otherwise the time is coarse n-1, fine floor(8*(thr-p)/(e-p)).
- R7: Peak mode (`det_mode`=1) takes as its time the index of the first sample holding the maximum excess, with fine 0.
- R8: The mode bit stored in a record is the value of `det_mode` at the opening sample.
- R9: For the `dead_len` valid samples after the closing sample, nothing can open a hit and the baseline does not move.
- R10: The coarse time counts valid samples only. The seeding sample is index 0. Cycles without `smp_valid` are ignored entirely.
- R11: Records leave in the order they were made. While `rec_valid` is high and `rec_ready` is low, `rec_valid` and `rec_data` hold.
- R12: A record that completes while the buffer already holds FIFO_DEPTH entries is discarded. `drop_count` then increases by one and saturates at all ones. It is 0 after reset.
- R13: The record layout is: fine time in bits [2:0], coarse time in [34:3], amplitude in [44:35], mode in [45].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 10 | ADC sample, unsigned |
| thr | input | 10 | Hit threshold above baseline |
| bl_shift | input | SHIFT_W | Baseline averaging shift (log2 of time constant) |
| dead_len | input | DEAD_W | Samples ignored after each hit |
| det_mode | input | 1 | 0 edge timing, 1 peak timing |
| rec_valid | output | 1 | Hit record available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_data | output | 46 | Hit record (layout in R13) |
| drop_count | output | DROP_W | Saturating count of lost records |

## Verification
The checks rely on the following input conditions:
- `thr` is at least 1 and does not change while a hit is open.
- `bl_shift` changes only across a reset.

Otherwise the amplitude bound and the baseline-freeze properties could see an inconsistent threshold or baseline scale. The stimulus follows these rules by changing every setting only while reset is asserted. It also keeps the pulse tops below full scale, so the excess always fits the amplitude field. Sample strobes come with irregular gaps between them, which exercises the rule that only valid samples advance time.

// File: rtl/hit_pkg.sv
package hit_pkg;

    localparam int SMP_W    = 10;
    localparam int COARSE_W = 32;
    localparam int FINE_W   = 3;

    typedef enum logic {
        DET_EDGE = 1'b0,
        DET_PEAK = 1'b1
    } det_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_DEAD = 2'd2
    } hit_state_e;

    typedef struct packed {
        det_mode_e             mode;
        logic [SMP_W-1:0]      amp;
        logic [COARSE_W-1:0]   coarse;
        logic [FINE_W-1:0]     fine;
    } hit_rec_t;

    localparam int REC_W = $bits(hit_rec_t);

    // floor(2^FINE_W * num / den) for num < den, by restoring division
    function automatic logic [FINE_W-1:0] frac_div(input logic [SMP_W:0] num,
                                                   input logic [SMP_W:0] den);
        logic [SMP_W+1:0]  rem;
        logic [FINE_W-1:0] q;
        rem = {1'b0, num};
        q   = '0;
        for (int i = FINE_W - 1; i >= 0; i--) begin
            rem = rem << 1;
            if (rem >= {1'b0, den}) begin
                rem  = rem - {1'b0, den};
                q[i] = 1'b1;
            end
        end
        return q;
    endfunction

endpackage

// File: rtl/hit_baseline.sv
module hit_baseline import hit_pkg::*; #(
    parameter int SHIFT_W     = 4,
    parameter int SHIFT_LIMIT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               upd,
    input  logic [SMP_W-1:0]   sample,
    input  logic [SHIFT_W-1:0] shift,
    output logic [SMP_W-1:0]   bl
);
    localparam int ACC_W = SMP_W + SHIFT_LIMIT;

    logic [ACC_W-1:0]   acc;
    logic [ACC_W:0]     acc_nxt;
    logic [SHIFT_W-1:0] sh;

    assign sh      = (shift > SHIFT_W'(SHIFT_LIMIT)) ? SHIFT_W'(SHIFT_LIMIT) : shift;
    assign bl      = SMP_W'(acc >> sh);
    assign acc_nxt = {1'b0, acc} + (ACC_W+1)'(sample) - (ACC_W+1)'(bl);

    always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (load) acc <= ACC_W'(sample) << sh;
        else if (upd)  acc <= ACC_W'(acc_nxt);
    end

    // R2: no load or update means the baseline holds (unless its scale changed)
    a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
        (!load && !upd) |=> (!$stable(shift) || $stable(bl)));

endmodule

// File: rtl/hit_finder.sv
module hit_finder import hit_pkg::*; #(
    parameter int DEAD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic [SMP_W-1:0]    d,
    input  logic [SMP_W-1:0]    thr,
    input  logic [DEAD_W-1:0]   dead_len,
    input  det_mode_e           mode_sel,
    input  logic [COARSE_W-1:0] idx,
    output logic                push,
    output hit_rec_t            rec,
    output logic                bl_upd
);
    hit_state_e          st;
    logic [SMP_W-1:0]    prev_d;
    logic [SMP_W-1:0]    pk;
    logic [DEAD_W-1:0]   dcnt;
    logic [COARSE_W-1:0] tc;
    logic [FINE_W-1:0]   tf;
    det_mode_e           mode_l;

    logic                trig;
    logic                on_thr;
    logic [COARSE_W-1:0] open_coarse;
    logic [FINE_W-1:0]   open_fine;

    always_comb begin
        trig   = (st == ST_IDLE) && (d >= thr) && (prev_d < thr);
        on_thr = (d == thr);
        if (mode_sel == DET_PEAK || on_thr) begin
            open_coarse = idx;
            open_fine   = '0;
        end else begin
            open_coarse = idx - COARSE_W'(1);
            open_fine   = frac_div({1'b0, thr} - {1'b0, prev_d},
                                   {1'b0, d}   - {1'b0, prev_d});
        end
    end

    assign bl_upd = step && (st == ST_IDLE) && !trig;
    assign push   = step && (st == ST_HIT) && (d < thr);
    assign rec    = '{mode: mode_l, amp: pk, coarse: tc, fine: tf};

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            prev_d <= '0;
            pk     <= '0;
            dcnt   <= '0;
            tc     <= '0;
            tf     <= '0;
            mode_l <= DET_EDGE;
        end else if (step) begin
            prev_d <= d;
            unique case (st)
                ST_IDLE: if (trig) begin
                    st     <= ST_HIT;
                    pk     <= d;
                    tc     <= open_coarse;
                    tf     <= open_fine;
                    mode_l <= mode_sel;
                end
                ST_HIT: begin
                    if (d < thr) begin
                        if (dead_len == '0) st <= ST_IDLE;
                        else begin
                            st   <= ST_DEAD;
                            dcnt <= dead_len;
                        end
                    end else if (d > pk) begin
                        pk <= d;
                        if (mode_l == DET_PEAK) tc <= idx;
                    end
                end
                ST_DEAD: begin
                    dcnt <= dcnt - DEAD_W'(1);
                    if (dcnt == DEAD_W'(1)) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R3: a closed hit always reached the threshold
    a_r3_amp_reaches_thr: assert property (@(posedge clk) disable iff (rst)
        push |-> (rec.amp >= thr));
    // R7: peak timing carries no fraction
    a_r7_peak_fine_zero: assert property (@(posedge clk) disable iff (rst)
        (push && rec.mode == DET_PEAK) |-> (rec.fine == '0));
    // R6: the interpolated crossing lies before the closing sample
    a_r6_edge_before_close: assert property (@(posedge clk) disable iff (rst)
        (push && rec.mode == DET_EDGE) |-> (rec.coarse < idx));
    // R9: a dead window with one sample left returns to idle
    a_r9_dead_exit: assert property (@(posedge clk) disable iff (rst)
        (step && st == ST_DEAD && dcnt == DEAD_W'(1)) |=> (st == ST_IDLE));

endmodule

// File: rtl/hit_fifo.sv
module hit_fifo import hit_pkg::*; #(
    parameter int DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  hit_rec_t din,
    output logic     full,
    output logic     out_valid,
    input  logic     out_ready,
    output hit_rec_t dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          wr_en, rd_en;
    hit_rec_t      slots [DEPTH];

    assign full      = (count == (AW+1)'(DEPTH));
    assign out_valid = (count != '0);
    assign wr_en     = push && !full;
    assign rd_en     = out_valid && out_ready;
    assign dout      = slots[rd_ptr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        hit_rec_t slot_q;
        always_ff @(posedge clk) begin
            if (rst)                                slot_q <= '0;
            else if (wr_en && wr_ptr == AW'(g))     slot_q <= din;
        end
        assign slots[g] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            count <= count + (AW+1)'(wr_en) - (AW+1)'(rd_en);
        end
    end

    // R11: an offered record is held until taken
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(dout)));

endmodule

// File: rtl/autotrig_hit_unit.sv
module autotrig_hit_unit import hit_pkg::*; #(
    parameter int FIFO_DEPTH  = 16,
    parameter int DROP_W      = 8,
    parameter int SHIFT_W     = 4,
    parameter int SHIFT_LIMIT = 8,
    parameter int DEAD_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_valid,
    input  logic [SMP_W-1:0]   smp_data,
    input  logic [SMP_W-1:0]   thr,
    input  logic [SHIFT_W-1:0] bl_shift,
    input  logic [DEAD_W-1:0]  dead_len,
    input  logic               det_mode,
    output logic               rec_valid,
    input  logic               rec_ready,
    output logic [REC_W-1:0]   rec_data,
    output logic [DROP_W-1:0]  drop_count
);
    logic                primed;
    logic [COARSE_W-1:0] smp_idx;
    logic [SMP_W-1:0]    bl;
    logic [SMP_W-1:0]    excess;
    logic                seed, step, bl_upd, hit_push, fifo_full, lost;
    hit_rec_t            hit_rec, head_rec;

    assign seed   = smp_valid && !primed;
    assign step   = smp_valid && primed;
    assign excess = (smp_data > bl) ? smp_data - bl : '0;
    assign lost   = hit_push && fifo_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed  <= 1'b0;
            smp_idx <= '0;
        end else if (smp_valid) begin
            primed  <= 1'b1;
            smp_idx <= smp_idx + COARSE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                            drop_count <= '0;
        else if (lost && drop_count != '1)  drop_count <= drop_count + DROP_W'(1);
    end

    hit_baseline #(.SHIFT_W(SHIFT_W), .SHIFT_LIMIT(SHIFT_LIMIT)) u_base (
        .clk    (clk),
        .rst    (rst),
        .load   (seed),
        .upd    (bl_upd),
        .sample (smp_data),
        .shift  (bl_shift),
        .bl     (bl)
    );

    hit_finder #(.DEAD_W(DEAD_W)) u_find (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .d        (excess),
        .thr      (thr),
        .dead_len (dead_len),
        .mode_sel (det_mode_e'(det_mode)),
        .idx      (smp_idx),
        .push     (hit_push),
        .rec      (hit_rec),
        .bl_upd   (bl_upd)
    );

    hit_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (hit_push),
        .din       (hit_rec),
        .full      (fifo_full),
        .out_valid (rec_valid),
        .out_ready (rec_ready),
        .dout      (head_rec)
    );

    assign rec_data = head_rec;

    // R12: saturated counter stays saturated
    a_r12_saturate: assert property (@(posedge clk) disable iff (rst)
        (drop_count == '1) |=> (drop_count == '1));
    // R12: the loss counter never goes down
    a_r12_monotonic: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drop_count >= $past(drop_count)));

endmodule

// File: tb/autotrig_hit_unit_tb.sv
module autotrig_hit_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int DW         = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [9:0]  smp_data = '0;
    logic [9:0]  thr = 10'd40;
    logic [3:0]  bl_shift = '0;
    logic [7:0]  dead_len = '0;
    logic        det_mode = 1'b0;
    logic        rec_valid;
    logic        rec_ready = 1'b1;
    logic [45:0] rec_data;
    logic [DW-1:0] drop_count;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [45:0] exp_q[$];

    // reference model state, from the requirements
    int m_acc, m_prev, m_st, m_dcnt, m_pk, m_tc, m_tf, m_mode, m_n, m_sh;
    bit m_primed;
    bit ovf_mode = 1'b0;
    int ovf_made, ovf_drops;

    always #(CLK_PERIOD/2) clk = ~clk;

    autotrig_hit_unit #(.FIFO_DEPTH(DEPTH), .DROP_W(DW)) u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .thr(thr), .bl_shift(bl_shift), .dead_len(dead_len), .det_mode(det_mode),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
        .drop_count(drop_count));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic emit();
        logic [45:0] r;
        r = {m_mode[0], m_pk[9:0], m_tc[31:0], m_tf[2:0]};   // R13 layout
        if (ovf_mode) begin
            if (ovf_made < DEPTH) exp_q.push_back(r);
            else ovf_drops++;
            ovf_made++;
        end else exp_q.push_back(r);
    endtask

    task automatic model(input int x);
        int bl, d;
        if (!m_primed) begin                      // R1 seeding
            m_acc = x << m_sh; m_primed = 1; m_n = 1; m_prev = 0;
            return;
        end
        bl = m_acc >> m_sh;                       // R2
        d  = (x > bl) ? x - bl : 0;               // R3
        case (m_st)
            0: if (d >= thr && m_prev < thr) begin // R4
                   m_st = 1; m_pk = d; m_mode = det_mode;
                   if (det_mode) begin m_tc = m_n; m_tf = 0; end       // R7
                   else if (d == thr) begin m_tc = m_n; m_tf = 0; end  // R6
                   else begin m_tc = m_n - 1; m_tf = (8 * (thr - m_prev)) / (d - m_prev); end
               end else m_acc = m_acc + x - bl;
            1: if (d < thr) begin                  // R5
                   emit();
                   if (dead_len == 0) m_st = 0;
                   else begin m_st = 2; m_dcnt = dead_len; end
               end else if (d > m_pk) begin
                   m_pk = d;
                   if (m_mode == 1) m_tc = m_n;
               end
            default: begin m_dcnt--; if (m_dcnt == 0) m_st = 0; end  // R9
        endcase
        m_prev = d;
        m_n++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        m_primed = 0; m_st = 0; m_prev = 0; m_acc = 0; m_n = 0;
        m_sh = (bl_shift > 8) ? 8 : int'(bl_shift);
    endtask

    task automatic send(input int x, input int gap);
        smp_data  = 10'(x);
        smp_valid = 1'b1;
        model(x);
        @(posedge clk); #1;
        smp_valid = 1'b0;
        repeat (gap) begin @(posedge clk); #1; end   // R10 idle cycles
    endtask

    task automatic settle();
        repeat (12) begin @(posedge clk); #1; end
        chk(exp_q.size() == 0, "R5 records pending", exp_q.size(), 0);
    endtask

    // output monitor away from the active edge
    always @(negedge clk) begin
        if (!rst && rec_valid && rec_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected record", rec_data[34:3], -1);
            end else begin
                chk(rec_data[2:0]   == exp_q[0][2:0],   "R6 R7 fine time", rec_data[2:0], exp_q[0][2:0]);
                chk(rec_data[34:3]  == exp_q[0][34:3],  "R10 coarse time", rec_data[34:3], exp_q[0][34:3]);
                chk(rec_data[44:35] == exp_q[0][44:35], "R3 R2 amplitude", rec_data[44:35], exp_q[0][44:35]);
                chk(rec_data[45]    == exp_q[0][45],    "R8 mode bit", rec_data[45], exp_q[0][45]);
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R5 watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        int base;
        int amps[6];
        int shifts[3];
        do_reset();
        // reset state
        chk(rec_valid == 1'b0, "R11 reset valid", rec_valid, 0);
        chk(drop_count == '0, "R12 reset drops", drop_count, 0);

        // R1: a large first sample only seeds the baseline
        thr = 10'd30; bl_shift = 4'd2;
        do_reset();
        for (int i = 0; i < 6; i++) send(700, i % 2);
        settle();
        chk(rec_valid == 1'b0, "R1 seed sample made a hit", rec_valid, 0);

        // main sweep: modes x shifts x dead windows x amplitudes
        thr = 10'd40;
        amps   = '{39, 40, 41, 50, 333, 800};
        shifts = '{0, 3, 11};                     // 11 clamps to the limit (R2)
        for (int md = 0; md < 2; md++)
            for (int si = 0; si < 3; si++)
                for (int dl = 0; dl < 3; dl += 2) begin
                    det_mode = md[0]; bl_shift = 4'(shifts[si]); dead_len = 8'(dl);
                    do_reset();
                    base = 200;
                    for (int k = 0; k < 4; k++) send(base, k % 3);
                    for (int a = 0; a < 6; a++) begin
                        // asymmetric single pulse
                        send(base + amps[a] / 4, 0);
                        send(base + amps[a], 1);
                        send(base + (amps[a] * 3) / 4, 0);
                        send(base + amps[a] / 8, 2);
                        for (int k = 0; k < 4; k++) send(base, k % 2);
                        // flat-topped pulse: first maximum wins (R7)
                        send(base + amps[a], 0);
                        send(base + amps[a], 1);
                        send(base + amps[a] / 2, 0);
                        for (int k = 0; k < 4; k++) send(base, 0);
                        // double bump: second may fall in the dead window (R9)
                        send(base + amps[a], 0);
                        send(base, 0);
                        send(base + amps[a], 0);
                        send(base, 1);
                        for (int k = 0; k < 5; k++) send(base, 0);
                        base = base + 3;                  // slow drift, tracked (R2)
                        for (int k = 0; k < 3; k++) send(base, 0);
                    end
                    settle();
                end

        // R12: overflow with a stalled consumer
        det_mode = 1'b1; bl_shift = 4'd2; dead_len = 8'd0; thr = 10'd40;
        rec_ready = 1'b0;
        do_reset();
        ovf_mode = 1'b1; ovf_made = 0; ovf_drops = 0;
        for (int k = 0; k < 3; k++) send(100, 0);
        for (int p = 0; p < 25; p++) begin
            send(100 + 300, 0);
            send(100, 0);
            send(100, 0);
        end
        repeat (3) begin @(posedge clk); #1; end
        chk(int'(drop_count) == ((ovf_drops > 15) ? 15 : ovf_drops), "R12 saturated drop count",
            drop_count, (ovf_drops > 15) ? 15 : ovf_drops);
        chk(rec_valid == 1'b1, "R11 held record", rec_valid, 1);
        ovf_mode = 1'b0;
        rec_ready = 1'b1;
        settle();
        chk(int'(drop_count) == 15, "R12 count after drain", drop_count, 15);

        done = 1'b1;
        finish_run();
    end
endmodule